// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Program Timer

This block sits between the serial command decoder of a serial EEPROM and its storage array. When the decoder reports that a page write has been addressed, the block opens a 32-byte page buffer. Each data byte that follows is placed in the next slot of that page. Only the low five address bits move, and they wrap inside the page, so bytes sent past the 32nd overwrite the ones loaded before them. The block also records which slots have been filled.

When chip select rises, the block decides whether to commit. The rise must land on a byte boundary, at least one data byte must have arrived, and the protection unit must grant the write. If all three hold, a self-timed busy interval of a parameterised number of system clocks starts. Early in that interval the filled slots are written to the array, one slot per clock, in ascending slot order. Slots that were never filled are left alone. In the last busy clock a completion pulse is given, which the surrounding logic uses to clear its write-enable latch. If any commit condition fails, the command is dropped and no interval starts.

A status-register write takes the same commit path. Its single byte is handed to the status register in the first busy clock, and the same busy interval follows. While the block is busy it ignores every new command strobe.

Top module: `eeprom_page_prog`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `mem_we`, `sr_we` and `done` are low.
- R2: Data bytes land in consecutive page slots starting at `wr_addr[4:0]`. Every array write issued for that page carries `wr_addr[12:5]` unchanged as `mem_addr[12:5]` and the slot number as `mem_addr[4:0]`.
- R3: After slot 31 the slot pointer wraps to slot 0. When more than 32 bytes are sent, each slot is written with the last byte that landed in it.
- R4: Array writes are issued only for slots that received a byte in the current page command.
- R5: A commit starts only when `cs_rise` is seen with `byte_aligned` high, `grant` high and at least one byte received. Otherwise the command is dropped and there is no busy interval, no array write and no `done`.
- R6: `busy` rises in the clock after an accepted `cs_rise` and stays high for exactly `PROG_CYCLES` clocks.
- R7: `done` is a single-clock pulse in the last busy clock, and it is given at no other time.
- R8: Array writes occur only while busy. The write to slot k is issued in busy clock k, counting the first busy clock as 0, so writes come in ascending slot order.
- R9: A byte given with `sr_stb` in the idle state follows the same commit rules. On commit, `sr_we` pulses once in busy clock 0 with `sr_wdata` equal to that byte. No array write is issued, the interval lasts `PROG_CYCLES` clocks and ends with `done`.
- R10: While busy, `wr_begin`, `byte_stb`, `sr_stb` and `cs_rise` have no effect: there are no extra writes, the interval is not extended, and no command stays pending after it ends.
- R11: A `byte_stb` received while no page command is open is ignored, and a following `cs_rise` starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | Page write command addressed; strobe |
| wr_addr | input | 13 | Start address of the page write |
| byte_stb | input | 1 | One data byte received; strobe |
| byte_data | input | 8 | Received data byte |
| sr_stb | input | 1 | Status-register write byte received; strobe |
| sr_data | input | 8 | Status-register byte |
| cs_rise | input | 1 | Chip select deasserted; strobe |
| byte_aligned | input | 1 | Bit counter sits on a byte boundary |
| grant | input | 1 | Protection unit allows this write |
| busy | output | 1 | Programming interval in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status-register write strobe |
| sr_wdata | output | 8 | Status-register write data |
| done | output | 1 | Programming complete; one-clock pulse |

## Verification
The hardest case to reach from the ports is a full command sequence arriving in the middle of a busy interval. If such a sequence were accepted, it would either stretch the interval or leave a half-open page behind that a later chip-select rise would commit. The stimulus drives page-open, data, status and chip-select strobes at chosen busy clocks. It then watches past the end of the interval, and afterwards gives a lone chip-select rise with grant and alignment held high, so that any leftover state would show up as a second cycle. The page wrap is reached by starting two slots below the top of a page and sending 35 bytes, which makes slots 30, 31 and 0 overwrite themselves.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BURN = 2'd2
  } epp_state_e;

  typedef enum logic {
    MD_PAGE = 1'b0,
    MD_STAT = 1'b1
  } epp_mode_e;
endpackage

// File: rtl/epp_page_buf.sv
// Page staging store: one byte per slot, a filled-slot mask and a wrapping pointer.
module epp_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_pg,
  input  logic [SLOT_W-1:0] ptr_init,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q, valid_d;
  logic [SLOT_W-1:0]     ptr_q, ptr_d;
  logic                  store_en;

  assign store_en = push && !open_pg;

  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    if (open_pg) begin
      valid_d = '0;
      ptr_d   = ptr_init;
    end else if (push) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d          = ptr_q + 1'b1;   // power-of-two page: wraps inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  // Data slots carry no reset; the valid mask qualifies them.
  always_ff @(posedge clk) begin
    if (store_en) slot_q[ptr_q] <= push_data;
  end

  assign rd_data  = slot_q[rd_slot];
  assign rd_valid = valid_q[rd_slot];
endmodule

// File: rtl/epp_prog_timer.sv
// Busy-interval counter: counts from 0 while run is high, flags the final clock.
module epp_prog_timer #(
  parameter int PROG_CYCLES = 20000,
  localparam int CNT_W      = $clog2(PROG_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = run && (cnt_q == LAST_CNT);
endmodule

// File: rtl/epp_ctrl.sv
// Command sequencer: idle -> collecting -> programming.
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [BASE_W-1:0] base_in,
  input  logic              byte_stb,
  input  logic              sr_stb,
  input  logic [DATA_W-1:0] sr_data,
  input  logic              cs_rise,
  input  logic              byte_aligned,
  input  logic              grant,
  input  logic              timer_last,
  output logic              buf_open,
  output logic              buf_push,
  output logic              run,
  output logic              mode_stat,
  output logic [BASE_W-1:0] base,
  output logic [DATA_W-1:0] sr_hold
);
  epp_state_e        state_q, state_d;
  epp_mode_e         mode_q, mode_d;
  logic              got_q, got_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    got_d    = got_q;
    base_d   = base_q;
    sr_d     = sr_q;
    buf_open = 1'b0;
    buf_push = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_begin) begin
          state_d  = ST_FILL;
          mode_d   = MD_PAGE;
          got_d    = 1'b0;
          base_d   = base_in;
          buf_open = 1'b1;
        end else if (sr_stb) begin
          state_d = ST_FILL;
          mode_d  = MD_STAT;
          got_d   = 1'b1;
          sr_d    = sr_data;
        end
      end
      ST_FILL: begin
        if (cs_rise) begin
          state_d = (byte_aligned && got_q && grant) ? ST_BURN : ST_IDLE;
        end else if (byte_stb && (mode_q == MD_PAGE)) begin
          buf_push = 1'b1;
          got_d    = 1'b1;
        end
      end
      ST_BURN: begin
        if (timer_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_PAGE;
      got_q   <= 1'b0;
      base_q  <= '0;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      got_q   <= got_d;
      base_q  <= base_d;
      sr_q    <= sr_d;
    end
  end

  assign run       = (state_q == ST_BURN);
  assign mode_stat = (mode_q == MD_STAT);
  assign base      = base_q;
  assign sr_hold   = sr_q;
endmodule

// File: rtl/eeprom_page_prog.sv
// Page write buffer and self-timed program sequencer. PROG_CYCLES must exceed PAGE_BYTES,
// and PAGE_BYTES must be a power of two.
module eeprom_page_prog #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              sr_stb,
  input  logic [DATA_W-1:0] sr_data,
  input  logic              cs_rise,
  input  logic              byte_aligned,
  input  logic              grant,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sr_we,
  output logic [DATA_W-1:0] sr_wdata,
  output logic              done
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - SLOT_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES);
  localparam logic [CNT_W:0] PAGE_LIM = (CNT_W+1)'(PAGE_BYTES);

  logic              buf_open, buf_push, run, mode_stat, tmr_last;
  logic [BASE_W-1:0] base;
  logic [CNT_W-1:0]  tmr_cnt;
  logic [SLOT_W-1:0] flush_slot;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, in_page;

  epp_ctrl #(
    .BASE_W (BASE_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_begin     (wr_begin),
    .base_in      (wr_addr[ADDR_W-1:SLOT_W]),
    .byte_stb     (byte_stb),
    .sr_stb       (sr_stb),
    .sr_data      (sr_data),
    .cs_rise      (cs_rise),
    .byte_aligned (byte_aligned),
    .grant        (grant),
    .timer_last   (tmr_last),
    .buf_open     (buf_open),
    .buf_push     (buf_push),
    .run          (run),
    .mode_stat    (mode_stat),
    .base         (base),
    .sr_hold      (sr_wdata)
  );

  epp_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_pg   (buf_open),
    .ptr_init  (wr_addr[SLOT_W-1:0]),
    .push      (buf_push),
    .push_data (byte_data),
    .rd_slot   (flush_slot),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  epp_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .cnt   (tmr_cnt),
    .last  (tmr_last)
  );

  // Flush walks the page in the first PAGE_BYTES clocks of the busy interval.
  assign flush_slot = tmr_cnt[SLOT_W-1:0];
  assign in_page    = ({1'b0, tmr_cnt} < PAGE_LIM);

  assign busy      = run;
  assign mem_we    = run && !mode_stat && in_page && rd_valid;
  assign mem_addr  = {base, flush_slot};
  assign mem_wdata = rd_data;
  assign sr_we     = run && mode_stat && (tmr_cnt == '0);
  assign done      = tmr_last;
endmodule

// File: rtl/eeprom_page_prog_chk.sv
module eeprom_page_prog_chk #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              byte_aligned,
  input logic              grant,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              sr_we,
  input logic              done
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int LEN_W  = $clog2(PROG_CYCLES) + 1;

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_slot_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy))
      |-> (mem_addr[SLOT_W-1:0] > $past(mem_addr[SLOT_W-1:0])));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy))
      |-> (mem_addr[ADDR_W-1:SLOT_W] == $past(mem_addr[ADDR_W-1:SLOT_W])));

  p_sr_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> (busy && !mem_we));

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_fall_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  p_start_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && byte_aligned && grant));

  p_len_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_q == LEN_W'(PROG_CYCLES - 1)));

  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q < LEN_W'(PROG_CYCLES)));
endmodule

bind eeprom_page_prog eeprom_page_prog_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_BYTES  (PAGE_BYTES),
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_rise      (cs_rise),
  .byte_aligned (byte_aligned),
  .grant        (grant),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .sr_we        (sr_we),
  .done         (done)
);

// File: tb/tb_eeprom_page_prog.sv
module tb_eeprom_page_prog;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 40;
  localparam int WIN        = PROG + 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_begin, byte_stb, sr_stb, cs_rise, byte_aligned, grant;
  logic [12:0] wr_addr;
  logic [7:0]  byte_data, sr_data;
  logic        busy, mem_we, sr_we, done;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, sr_wdata;

  int n_chk = 0;
  int n_err = 0;

  int          n_busy, first_busy, n_done, done_k, n_wr, n_sr, sr_k;
  logic [7:0]  sr_d;
  logic [12:0] wr_a [64];
  logic [7:0]  wr_d [64];
  int          wr_k [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_prog #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .sr_stb(sr_stb), .sr_data(sr_data),
    .cs_rise(cs_rise), .byte_aligned(byte_aligned), .grant(grant),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic open_page(input logic [12:0] a);
    @(negedge clk); wr_begin = 1'b1; wr_addr = a;
    @(negedge clk); wr_begin = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1'b1; byte_data = d;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic send_sr(input logic [7:0] d);
    @(negedge clk); sr_stb = 1'b1; sr_data = d;
    @(negedge clk); sr_stb = 1'b0;
  endtask

  // Raises cs_rise, then watches WIN clocks; k=0 is the first possible busy clock.
  task automatic commit(input logic al, input logic gr, input bit intrude);
    @(negedge clk); cs_rise = 1'b1; byte_aligned = al; grant = gr;
    @(negedge clk); cs_rise = 1'b0;
    n_busy = 0; first_busy = -1; n_done = 0; done_k = -1; n_wr = 0; n_sr = 0; sr_k = -1; sr_d = '0;
    for (int k = 0; k < WIN; k++) begin
      if (busy) begin n_busy++; if (first_busy < 0) first_busy = k; end
      if (done) begin n_done++; done_k = k; end
      if (mem_we && n_wr < 64) begin
        wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; wr_k[n_wr] = k; n_wr++;
      end
      if (sr_we) begin n_sr++; sr_k = k; sr_d = sr_wdata; end
      if (intrude) begin
        case (k)
          5:  begin wr_begin = 1'b1; wr_addr = 13'h0000; end
          6:  begin wr_begin = 1'b0; byte_stb = 1'b1; byte_data = 8'hAA; end
          7:  begin byte_stb = 1'b0; sr_stb = 1'b1; sr_data = 8'hFF; end
          8:  begin sr_stb = 1'b0; cs_rise = 1'b1; end
          9:  cs_rise = 1'b0;
          default: ;
        endcase
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_none(input string req);
    chk(req, n_busy, 0);
    chk(req, n_wr, 0);
    chk(req, n_done, 0);
    chk(req, n_sr, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 sr_we", sr_we, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_single;
    open_page(13'h0A45);
    send_byte(8'h3C);
    commit(1'b1, 1'b1, 1'b0);
    chk("R6 busy start", first_busy, 0);
    chk("R6 busy length", n_busy, PROG);
    chk("R7 done count", n_done, 1);
    chk("R7 done clock", done_k, PROG - 1);
    chk("R4 single write count", n_wr, 1);
    chk("R2 address", wr_a[0], 13'h0A45);
    chk("R2 data", wr_d[0], 8'h3C);
    chk("R8 slot clock", wr_k[0], 5);
  endtask

  task automatic t_wrap;
    logic [7:0] exp_d [32];
    open_page(13'h1FFE);
    for (int i = 0; i < 35; i++) begin
      exp_d[(30 + i) % 32] = 8'(8'h40 + i);
      send_byte(8'(8'h40 + i));
    end
    commit(1'b1, 1'b1, 1'b0);
    chk("R3 full page writes", n_wr, 32);
    for (int j = 0; j < 32; j++) begin
      chk("R3 wrap address", wr_a[j], 13'h1FE0 + j);
      chk("R3 last byte wins", wr_d[j], exp_d[j]);
      chk("R8 ascending clock", wr_k[j], j);
    end
  endtask

  task automatic t_partial;
    open_page(13'h0103);
    for (int i = 0; i < 4; i++) send_byte(8'(8'hC0 + i));
    commit(1'b1, 1'b1, 1'b0);
    chk("R4 partial count", n_wr, 4);
    for (int j = 0; j < 4; j++) begin
      chk("R4 partial address", wr_a[j], 13'h0103 + j);
      chk("R4 partial data", wr_d[j], 8'hC0 + j);
      chk("R8 partial clock", wr_k[j], 3 + j);
    end
  endtask

  task automatic t_reject;
    open_page(13'h0200); send_byte(8'h11);
    commit(1'b0, 1'b1, 1'b0);
    expect_none("R5 misaligned");
    open_page(13'h0200); send_byte(8'h22);
    commit(1'b1, 1'b0, 1'b0);
    expect_none("R5 no grant");
    open_page(13'h0200);
    commit(1'b1, 1'b1, 1'b0);
    expect_none("R5 no byte");
  endtask

  task automatic t_status;
    send_sr(8'h0C);
    commit(1'b1, 1'b1, 1'b0);
    chk("R9 sr pulses", n_sr, 1);
    chk("R9 sr clock", sr_k, 0);
    chk("R9 sr data", sr_d, 8'h0C);
    chk("R9 no array write", n_wr, 0);
    chk("R9 busy length", n_busy, PROG);
    chk("R9 done", n_done, 1);
    send_sr(8'h08);
    commit(1'b1, 1'b0, 1'b0);
    expect_none("R9 no grant");
  endtask

  task automatic t_busy_ignore;
    open_page(13'h0500);
    send_byte(8'h5A); send_byte(8'hA5);
    commit(1'b1, 1'b1, 1'b1);
    chk("R10 busy length", n_busy, PROG);
    chk("R10 writes", n_wr, 2);
    chk("R10 sr", n_sr, 0);
    chk("R10 done", n_done, 1);
    commit(1'b1, 1'b1, 1'b0);
    expect_none("R10 nothing pending");
  endtask

  task automatic t_idle_byte;
    send_byte(8'h55);
    commit(1'b1, 1'b1, 1'b0);
    expect_none("R11 idle byte");
  endtask

  initial begin
    rst_n = 1'b0;
    wr_begin = 1'b0; byte_stb = 1'b0; sr_stb = 1'b0; cs_rise = 1'b0;
    byte_aligned = 1'b0; grant = 1'b0;
    wr_addr = '0; byte_data = '0; sr_data = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_wrap;
    t_partial;
    t_reject;
    t_status;
    t_busy_ignore;
    t_idle_byte;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule